// File: doc/BRIEF.md
# Display Link PLL Setting Calculator

This block turns two numbers into the settings a display serial-link transmitter needs for its bit clock. One number is the reference clock in kHz. The other is the wanted bit rate per lane in kbps. A start strobe captures both inputs. The block then works out four things:

- the pre-divider;
- the feedback multiplier;
- the frequency band code;
- the low-power clock divider field.

It returns the packed 16-bit PLL word, the PLL frequency that the word really produces, and the 6-bit low-power field. A one-cycle done pulse marks the cycle in which all of these are valid.

There are no combinational dividers. The pre-divider comes from a compare-and-step search, one candidate per cycle, stopped at the largest value the field can hold. Every quotient comes from a single shared restoring divider that resolves one bit per cycle. It is used four times in a row:

1. the rounded-up multiplier;
2. the untruncated output frequency, from which the band code is chosen;
3. the frequency decoded back from the packed word;
4. the rounded-up low-power divider.

A zero reference cannot be divided by. It is reported with an error flag, and the calculation ends at once.

Top module: `pll_calc`

## Requirements
- R1: After reset, done, busy and err are 0 and pll_word, pll_freq and lp_field are 0.
- R2: The pre-divider d starts at 1. It steps up by one while ref_khz/(d+1) >= 5000 and d < 31, and its final value appears in pll_word[12:8].
- R3: The multiplier m is ceil(rate_kbps * d / ref_khz), computed at full precision, and its low 8 bits appear in pll_word[7:0].
- R4: pll_word[15:14] holds the band code and pll_word[13] is 0. The code is taken from f = floor(ref_khz * m / d) with the full-width m: 3 if f >= 501000, 2 if f >= 251000, 1 if f >= 126000, else 0.
- R5: pll_freq is floor(ref_khz * m8 / d8). Here m8 is pll_word[7:0] and d8 is pll_word[12:8], and either one is taken as 1 when its field is 0.
- R6: lp_field is (ceil(pll_freq / 80000) - 1) modulo 64.
- R7: done is high for exactly one cycle, and all three results are valid in that cycle. The results do not change until the next done. busy is high from the cycle after an accepted start up to done, and is low while done is high.
- R8: A start pulse while busy is high is ignored. The running calculation finishes with the results of the inputs captured at its own start.
- R9: A start with ref_khz = 0 while idle gives done and err in the next cycle, with pll_word, pll_freq and lp_field all 0.
- R10: The next accepted start with a nonzero reference clears err, and err stays 0 at that calculation's done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Starts a calculation when idle |
| ref_khz | input | 32 | Reference clock in kHz |
| rate_kbps | input | 32 | Wanted per-lane bit rate in kbps |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse: results valid |
| err | output | 1 | Last start had a zero reference |
| pll_word | output | 16 | Packed band / pre-divider / multiplier word |
| pll_freq | output | 40 | Frequency decoded from pll_word, kHz |
| lp_field | output | 6 | Low-power clock divider field |

## Verification
The bench uses a range of reference clocks, and each range tests a different part of the logic:

- A reference below 10000 kHz keeps the pre-divider at 1.
- References of exactly 10000 and 155000 kHz sit on the search's step boundary.
- References above 155000 kHz force the cap at 31.

The wanted rates are chosen to test the rest:

- Rates that land exactly on the band thresholds, or one step below them, separate each band code from its neighbour.
- A zero rate gives a zero multiplier field, which tests the decode-as-one rule.
- A multiplier above 255 gives a band code that differs from what the truncated field alone would suggest.
- A large decoded frequency makes the low-power field wrap modulo 64.

Directed runs cover the zero reference, a start issued mid-calculation, and the holding of results after done.

// File: rtl/pll_calc_pkg.sv
package pll_calc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEARCH,
    ST_MUL,
    ST_OUT,
    ST_DEC,
    ST_LP
  } calc_state_t;

  localparam int BAND1_KHZ = 126000;
  localparam int BAND2_KHZ = 251000;
  localparam int BAND3_KHZ = 501000;

endpackage

// File: rtl/pll_seq_div.sv
// Restoring shift-subtract divider, one quotient bit per cycle.
module pll_seq_div #(
  parameter int NW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [NW-1:0] num,
  input  logic [NW-1:0] den,
  output logic          busy,
  output logic          valid,
  output logic [NW-1:0] quo
);
  localparam int CW = $clog2(NW + 1);

  logic [NW-1:0] rem_q, rem_n, dsor_q, q_q, q_n;
  logic [NW:0]   rem_sh;
  logic [CW-1:0] cnt_q;

  always_comb begin
    rem_sh = {rem_q, q_q[NW-1]};
    if (rem_sh >= {1'b0, dsor_q}) begin
      rem_n = rem_sh[NW-1:0] - dsor_q;
      q_n   = {q_q[NW-2:0], 1'b1};
    end else begin
      rem_n = rem_sh[NW-1:0];
      q_n   = {q_q[NW-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      q_q    <= '0;
      dsor_q <= '0;
      cnt_q  <= '0;
      busy   <= 1'b0;
      valid  <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (go && !busy) begin
        rem_q  <= '0;
        q_q    <= num;
        dsor_q <= den;
        cnt_q  <= CW'(NW);
        busy   <= 1'b1;
      end else if (busy) begin
        rem_q <= rem_n;
        q_q   <= q_n;
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          busy  <= 1'b0;
          valid <= 1'b1;
        end
      end
    end
  end

  assign quo = q_q;
endmodule

// File: rtl/pll_prediv_search.sv
// Steps the pre-divider while the divided reference stays at or above STEP_KHZ.
module pll_prediv_search #(
  parameter int FREQ_W   = 32,
  parameter int DIV_W    = 5,
  parameter int STEP_KHZ = 5000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [FREQ_W-1:0] ref_khz,
  output logic              done,
  output logic [DIV_W-1:0]  div
);
  localparam int TW = FREQ_W + DIV_W + 1;
  localparam logic [DIV_W-1:0] DMAX = {DIV_W{1'b1}};

  logic [TW-1:0] thr_q;
  logic          run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q <= '0;
      run_q <= 1'b0;
      done  <= 1'b0;
      div   <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        div   <= DIV_W'(1);
        thr_q <= TW'(2 * STEP_KHZ);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (div != DMAX && TW'(ref_khz) >= thr_q) begin
          div   <= div + DIV_W'(1);
          thr_q <= thr_q + TW'(STEP_KHZ);
        end else begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pll_band_sel.sv
// Chooses the output band code from frequency thresholds.
module pll_band_sel #(
  parameter int VW = 40,
  parameter int T1 = pll_calc_pkg::BAND1_KHZ,
  parameter int T2 = pll_calc_pkg::BAND2_KHZ,
  parameter int T3 = pll_calc_pkg::BAND3_KHZ
) (
  input  logic [VW-1:0] freq,
  output logic [1:0]    band
);
  always_comb begin
    if (freq >= VW'(T3))      band = 2'd3;
    else if (freq >= VW'(T2)) band = 2'd2;
    else if (freq >= VW'(T1)) band = 2'd1;
    else                      band = 2'd0;
  end
endmodule

// File: rtl/pll_calc.sv
module pll_calc
  import pll_calc_pkg::*;
#(
  parameter int FREQ_W     = 32,
  parameter int MUL_W      = 8,
  parameter int DIV_W      = 5,
  parameter int LP_W       = 6,
  parameter int MIN_IF_KHZ = 5000,
  parameter int LP_MAX_KHZ = 10000,
  parameter int LP_RATIO   = 8,
  localparam int PW        = 2 * FREQ_W + DIV_W,
  localparam int PF_W      = FREQ_W + MUL_W,
  localparam int WORD_W    = 2 + 1 + DIV_W + MUL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [FREQ_W-1:0] ref_khz,
  input  logic [FREQ_W-1:0] rate_kbps,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [WORD_W-1:0] pll_word,
  output logic [PF_W-1:0]   pll_freq,
  output logic [LP_W-1:0]   lp_field
);
  localparam int LP_DEN = LP_MAX_KHZ * LP_RATIO;

  calc_state_t state_q;

  logic [FREQ_W-1:0] ref_q, rate_q;
  logic [DIV_W-1:0]  pdiv_q;
  logic [MUL_W-1:0]  mul_lo_q;
  logic [WORD_W-1:0] word_n;
  logic [PF_W-1:0]   freq_n;

  logic              sr_go, sr_done;
  logic [DIV_W-1:0]  sr_div;

  logic              dv_go, dv_busy, dv_valid;
  logic [PW-1:0]     dv_num, dv_den, dv_quo;

  logic [1:0]        band;
  logic [MUL_W-1:0]  m_dec;
  logic [DIV_W-1:0]  d_dec;

  pll_prediv_search #(
    .FREQ_W   (FREQ_W),
    .DIV_W    (DIV_W),
    .STEP_KHZ (MIN_IF_KHZ)
  ) search_i (
    .clk     (clk),
    .rst     (rst),
    .go      (sr_go),
    .ref_khz (ref_q),
    .done    (sr_done),
    .div     (sr_div)
  );

  pll_seq_div #(.NW(PW)) div_i (
    .clk   (clk),
    .rst   (rst),
    .go    (dv_go),
    .num   (dv_num),
    .den   (dv_den),
    .busy  (dv_busy),
    .valid (dv_valid),
    .quo   (dv_quo)
  );

  pll_band_sel #(.VW(PW)) band_i (
    .freq (dv_quo),
    .band (band)
  );

  // Zero fields decode as one.
  always_comb begin
    m_dec = (mul_lo_q == '0) ? MUL_W'(1) : mul_lo_q;
    d_dec = (pdiv_q == '0) ? DIV_W'(1) : pdiv_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      ref_q    <= '0;
      rate_q   <= '0;
      pdiv_q   <= '0;
      mul_lo_q <= '0;
      word_n   <= '0;
      freq_n   <= '0;
      sr_go    <= 1'b0;
      dv_go    <= 1'b0;
      dv_num   <= '0;
      dv_den   <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      pll_word <= '0;
      pll_freq <= '0;
      lp_field <= '0;
    end else begin
      done  <= 1'b0;
      sr_go <= 1'b0;
      dv_go <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            if (ref_khz == '0) begin
              err      <= 1'b1;
              done     <= 1'b1;
              pll_word <= '0;
              pll_freq <= '0;
              lp_field <= '0;
            end else begin
              err     <= 1'b0;
              ref_q   <= ref_khz;
              rate_q  <= rate_kbps;
              sr_go   <= 1'b1;
              busy    <= 1'b1;
              state_q <= ST_SEARCH;
            end
          end
        end
        ST_SEARCH: begin
          if (sr_done) begin
            pdiv_q  <= sr_div;
            dv_num  <= PW'(rate_q) * PW'(sr_div) + PW'(ref_q) - PW'(1);
            dv_den  <= PW'(ref_q);
            dv_go   <= 1'b1;
            state_q <= ST_MUL;
          end
        end
        ST_MUL: begin
          if (dv_valid) begin
            mul_lo_q <= dv_quo[MUL_W-1:0];
            dv_num   <= PW'(ref_q) * dv_quo;
            dv_den   <= PW'(pdiv_q);
            dv_go    <= 1'b1;
            state_q  <= ST_OUT;
          end
        end
        ST_OUT: begin
          if (dv_valid) begin
            word_n  <= {band, 1'b0, pdiv_q, mul_lo_q};
            dv_num  <= PW'(ref_q) * PW'(m_dec);
            dv_den  <= PW'(d_dec);
            dv_go   <= 1'b1;
            state_q <= ST_DEC;
          end
        end
        ST_DEC: begin
          if (dv_valid) begin
            freq_n  <= dv_quo[PF_W-1:0];
            dv_num  <= dv_quo + PW'(LP_DEN - 1);
            dv_den  <= PW'(LP_DEN);
            dv_go   <= 1'b1;
            state_q <= ST_LP;
          end
        end
        ST_LP: begin
          if (dv_valid) begin
            pll_word <= word_n;
            pll_freq <= freq_n;
            lp_field <= dv_quo[LP_W-1:0] - LP_W'(1);
            done     <= 1'b1;
            busy     <= 1'b0;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_calc_chk.sv
module pll_calc_chk #(
  parameter int FREQ_W = 32,
  parameter int WORD_W = 16,
  parameter int PF_W   = 40,
  parameter int LP_W   = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [FREQ_W-1:0] ref_khz,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [WORD_W-1:0] pll_word,
  input logic [PF_W-1:0]   pll_freq,
  input logic [LP_W-1:0]   lp_field,
  input logic              dv_go,
  input logic              dv_busy
);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(pll_word) && $stable(pll_freq) && $stable(lp_field)));

  p_idle_at_done_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_zero_ref_r9: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && ref_khz == '0) |=> (done && err));

  p_err_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (pll_word == '0 && pll_freq == '0 && lp_field == '0));

  p_prediv_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> (pll_word[WORD_W-4:WORD_W-8] != '0));

  p_div_launch_r8: assert property (@(posedge clk) disable iff (rst)
    dv_go |-> !dv_busy);
endmodule

bind pll_calc pll_calc_chk #(
  .FREQ_W (FREQ_W),
  .WORD_W (WORD_W),
  .PF_W   (PF_W),
  .LP_W   (LP_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .ref_khz  (ref_khz),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .pll_word (pll_word),
  .pll_freq (pll_freq),
  .lp_field (lp_field),
  .dv_go    (dv_go),
  .dv_busy  (dv_busy)
);

// File: tb/pll_calc_tb_top.sv
module pll_calc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;
  // {ref_khz, rate_kbps}
  localparam logic [63:0] VEC [NV] = '{
    {32'd27000,   32'd480000},
    {32'd4000,    32'd100000},
    {32'd9999,    32'd300000},
    {32'd10000,   32'd300000},
    {32'd155000,  32'd700000},
    {32'd200000,  32'd1000000},
    {32'd1000,    32'd501000},
    {32'd1000,    32'd500000},
    {32'd1000,    32'd251000},
    {32'd1000,    32'd126000},
    {32'd1000,    32'd125000},
    {32'd50000,   32'd0},
    {32'd4000,    32'd1500000},
    {32'd4000000, 32'd6000000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] ref_khz = '0;
  logic [31:0] rate_kbps = '0;
  logic        busy, done, err;
  logic [15:0] pll_word;
  logic [39:0] pll_freq;
  logic [5:0]  lp_field;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pll_calc dut_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .ref_khz   (ref_khz),
    .rate_kbps (rate_kbps),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .pll_word  (pll_word),
    .pll_freq  (pll_freq),
    .lp_field  (lp_field)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected results from the requirements.
  task automatic model(input logic [31:0] r, input logic [31:0] t,
                       output logic [15:0] w, output logic [39:0] f,
                       output logic [5:0] lp);
    logic [127:0] d, m, o, m8, ff, lpd;
    logic [1:0]   b;
    d = 1;
    while (d < 31 && (128'(r) / (d + 1)) >= 5000) d = d + 1;
    m = (128'(t) * d + 128'(r) - 1) / 128'(r);
    o = 128'(r) * m / d;
    if (o >= 501000) b = 3;
    else if (o >= 251000) b = 2;
    else if (o >= 126000) b = 1;
    else b = 0;
    w  = {b, 1'b0, d[4:0], m[7:0]};
    m8 = (m[7:0] == 0) ? 128'd1 : 128'(m[7:0]);
    ff = 128'(r) * m8 / d;
    f  = ff[39:0];
    lpd = (ff + 79999) / 80000;
    lp = lpd[5:0] - 6'd1;
  endtask

  task automatic pulse_start(input logic [31:0] r, input logic [31:0] t);
    @(negedge clk);
    ref_khz = r; rate_kbps = t; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (done !== 1'b1 && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    if (cyc >= 2000) chk("R7 watchdog wait", 0, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] ew;
    logic [39:0] ef;
    logic [5:0]  el;
    logic [15:0] hw;
    int cyc;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 done", done, 0);
    chk("R1 busy", busy, 0);
    chk("R1 err", err, 0);
    chk("R1 word", pll_word, 0);
    chk("R1 freq", pll_freq, 0);
    chk("R1 lp", lp_field, 0);

    // Hand-worked case: ref 27000, rate 480000 -> d=5, m=89, band 2, f=480600, lp=6
    pulse_start(32'd27000, 32'd480000);
    chk("R7 busy during run", busy, 1);
    wait_done(cyc);
    chk("R4 hand word", pll_word, 16'h8559);
    chk("R5 hand freq", pll_freq, 480600);
    chk("R6 hand lp", lp_field, 6);

    for (int i = 0; i < NV; i++) begin
      model(VEC[i][63:32], VEC[i][31:0], ew, ef, el);
      pulse_start(VEC[i][63:32], VEC[i][31:0]);
      wait_done(cyc);
      chk("R2 prediv field", pll_word[12:8], ew[12:8]);
      chk("R3 mul field", pll_word[7:0], ew[7:0]);
      chk("R4 band and spare", pll_word[15:13], ew[15:13]);
      chk("R5 decoded freq", pll_freq, ef);
      chk("R6 lp field", lp_field, el);
      chk("R7 busy low at done", busy, 0);
      chk("R10 err clear", err, 0);
      @(negedge clk);
      chk("R7 done one cycle", done, 0);
    end

    // R7 hold after done
    hw = pll_word;
    repeat (5) @(negedge clk);
    chk("R7 hold word", pll_word, hw);

    // R8 start while busy ignored
    model(32'd27000, 32'd480000, ew, ef, el);
    pulse_start(32'd27000, 32'd480000);
    repeat (4) @(negedge clk);
    pulse_start(32'd4000000, 32'd6000000);
    wait_done(cyc);
    chk("R8 word of first inputs", pll_word, ew);
    chk("R8 freq of first inputs", pll_freq, ef);
    @(negedge clk);
    chk("R8 no second run", busy, 0);

    // R9 zero reference
    @(negedge clk);
    ref_khz = 0; rate_kbps = 32'd480000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 done next cycle", done, 1);
    chk("R9 err", err, 1);
    chk("R9 word zero", pll_word, 0);
    chk("R9 freq zero", pll_freq, 0);
    chk("R9 lp zero", lp_field, 0);
    @(negedge clk);
    chk("R9 err held", err, 1);

    // R10 err clears on next valid run
    model(32'd10000, 32'd300000, ew, ef, el);
    pulse_start(32'd10000, 32'd300000);
    chk("R10 err cleared at accept", err, 0);
    wait_done(cyc);
    chk("R10 err at done", err, 0);
    chk("R10 word", pll_word, ew);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule